// File: doc/BRIEF.md
# Polarity-Aware General-Purpose I/O Port

This block is one bank of general-purpose I/O lines behind a simple register bus. Software sets, per line, an output latch, a direction bit, a blink enable and an input polarity bit. The pad side gets an output-enable and an output value for every line. Incoming pad levels pass through a two-flop synchronizer. They are then XORed with the polarity register. The result can be read back as a data-in register, and the same vector goes to a neighbouring interrupt unit.

A small blink timer runs freely from reset. It is a two-state machine. State `BLK_HOLD` passes the latch value to the pad. State `BLK_INVERT` passes its inverse. Each state lasts `BLINK_HALF` clock cycles. Transition `HOLD->INVERT` fires when the prescaler reaches its last count in `BLK_HOLD`. Transition `INVERT->HOLD` fires on the same count in `BLK_INVERT`. Otherwise the machine stays where it is and the prescaler advances. Only output lines with blink enabled are affected.

`NLINES` sets how many lines exist, up to 32. Register bits at and above that count are not stored and read as zero.

Top module: `gpio_pol_port`

## Requirements
- R1: After reset every line is an input (pad_oe all zero), the direction register reads all implemented bits set, and the output, blink and polarity registers read zero.
- R2: Registers sit at byte offsets output 0x00, direction 0x04, blink 0x08, polarity 0x0C and data-in 0x10. A write lands on the next rising edge. bus_rdata shows the addressed register combinationally in the same cycle.
- R3: A direction bit of 1 makes its line an input, with the output driver released (pad_oe low). A bit of 0 sets pad_oe high, and pad_out then carries the output latch bit when blink is off.
- R4: Data-in bit n, and irq_level bit n, equal the pad level of line n XOR polarity bit n. The pad level is taken through two flops, so a pad change shows after the second rising edge and not after the first.
- R5: An output line with blink enabled drives its latch value for BLINK_HALF cycles and the inverse for BLINK_HALF cycles, repeating. The timer runs freely from reset and starts in the hold state.
- R6: Bits at and above NLINES are not stored, and every register reads zero there.
- R7: A write to the data-in offset has no effect on any register or output.
- R8: Offsets other than the five mapped ones, including unaligned ones, read as zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte offset of the register accessed |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pad_in | input | NLINES | Raw pad levels, asynchronous |
| pad_oe | output | NLINES | Output enable per line |
| pad_out | output | NLINES | Driven value per line |
| irq_level | output | NLINES | Polarity-adjusted input vector for the interrupt unit |

## Verification
Register readback is due in the same cycle as the address, so the bench drives the address at a falling edge and samples before the next rising edge. Write effects on pad_oe and pad_out are due one rising edge after the strobe, so the bench samples them at the following falling edge. Data-in and irq_level are due two rising edges after a pad change; the bench checks the old value after one edge and the new value after two. Blink timing is checked by measuring run lengths of pad_out between transitions, each sampled at a falling edge, against BLINK_HALF.

// File: rtl/gpio_pol_pkg.sv
`timescale 1ns/1ps
package gpio_pol_pkg;
    localparam int unsigned OFS_OUT   = 32'h00;
    localparam int unsigned OFS_DIR   = 32'h04;
    localparam int unsigned OFS_BLINK = 32'h08;
    localparam int unsigned OFS_POL   = 32'h0C;
    localparam int unsigned OFS_DIN   = 32'h10;

    typedef enum logic {
        BLK_HOLD   = 1'b0,
        BLK_INVERT = 1'b1
    } blink_state_e;
endpackage

// File: rtl/gpio_pol_sync.sv
`timescale 1ns/1ps
module gpio_pol_sync #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] d_sync
);
    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= d_async;
            stage2_q <= stage1_q;
        end
    end

    assign d_sync = stage2_q;
endmodule

// File: rtl/gpio_pol_blink.sv
`timescale 1ns/1ps
module gpio_pol_blink
    import gpio_pol_pkg::*;
#(
    parameter int unsigned HALF = 50000
) (
    input  logic clk,
    input  logic rst_n,
    output logic hold_phase
);
    localparam int unsigned CNT_W = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HALF - 1);

    blink_state_e     state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             wrap;

    assign wrap = (cnt_q == CNT_LAST);

    always_comb begin
        state_d = state_q;
        cnt_d   = wrap ? '0 : cnt_q + 1'b1;
        unique case (state_q)
            BLK_HOLD:   if (wrap) state_d = BLK_INVERT;
            BLK_INVERT: if (wrap) state_d = BLK_HOLD;
            default:    state_d = BLK_HOLD;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= BLK_HOLD;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        unique case (state_q)
            BLK_HOLD:   hold_phase = 1'b1;
            BLK_INVERT: hold_phase = 1'b0;
            default:    hold_phase = 1'b1;
        endcase
    end
endmodule

// File: rtl/gpio_pol_regs.sv
`timescale 1ns/1ps
module gpio_pol_regs
    import gpio_pol_pkg::*;
#(
    parameter int unsigned NLINES = 32,
    parameter int unsigned ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [NLINES-1:0] din_vec,
    output logic [NLINES-1:0] out_q,
    output logic [NLINES-1:0] dir_q,
    output logic [NLINES-1:0] blink_q,
    output logic [NLINES-1:0] pol_q
);
    localparam logic [ADDR_W-1:0] A_OUT   = ADDR_W'(OFS_OUT);
    localparam logic [ADDR_W-1:0] A_DIR   = ADDR_W'(OFS_DIR);
    localparam logic [ADDR_W-1:0] A_BLINK = ADDR_W'(OFS_BLINK);
    localparam logic [ADDR_W-1:0] A_POL   = ADDR_W'(OFS_POL);
    localparam logic [ADDR_W-1:0] A_DIN   = ADDR_W'(OFS_DIN);

    logic [NLINES-1:0] wval;
    assign wval = bus_wdata[NLINES-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q   <= '0;
            dir_q   <= '1;
            blink_q <= '0;
            pol_q   <= '0;
        end else if (bus_we) begin
            if (bus_addr == A_OUT)   out_q   <= wval;
            if (bus_addr == A_DIR)   dir_q   <= wval;
            if (bus_addr == A_BLINK) blink_q <= wval;
            if (bus_addr == A_POL)   pol_q   <= wval;
        end
    end

    always_comb begin
        case (bus_addr)
            A_OUT:   bus_rdata = 32'(out_q);
            A_DIR:   bus_rdata = 32'(dir_q);
            A_BLINK: bus_rdata = 32'(blink_q);
            A_POL:   bus_rdata = 32'(pol_q);
            A_DIN:   bus_rdata = 32'(din_vec);
            default: bus_rdata = 32'd0;
        endcase
    end
endmodule

// File: rtl/gpio_pol_port.sv
`timescale 1ns/1ps
module gpio_pol_port #(
    parameter int unsigned NLINES     = 32,
    parameter int unsigned ADDR_W     = 8,
    parameter int unsigned BLINK_HALF = 50000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [NLINES-1:0] pad_in,
    output logic [NLINES-1:0] pad_oe,
    output logic [NLINES-1:0] pad_out,
    output logic [NLINES-1:0] irq_level
);
    logic [NLINES-1:0] pad_sync;
    logic [NLINES-1:0] din_vec;
    logic [NLINES-1:0] out_q, dir_q, blink_q, pol_q;
    logic              blink_hold;

    gpio_pol_sync #(.W(NLINES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (pad_in),
        .d_sync  (pad_sync)
    );

    gpio_pol_blink #(.HALF(BLINK_HALF)) u_blink (
        .clk        (clk),
        .rst_n      (rst_n),
        .hold_phase (blink_hold)
    );

    gpio_pol_regs #(.NLINES(NLINES), .ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .din_vec   (din_vec),
        .out_q     (out_q),
        .dir_q     (dir_q),
        .blink_q   (blink_q),
        .pol_q     (pol_q)
    );

    assign din_vec   = pad_sync ^ pol_q;
    assign irq_level = din_vec;
    assign pad_oe    = ~dir_q;
    assign pad_out   = out_q ^ (blink_q & ~dir_q & {NLINES{~blink_hold}});
endmodule

// File: rtl/gpio_pol_port_chk.sv
`timescale 1ns/1ps
module gpio_pol_port_chk
    import gpio_pol_pkg::*;
#(
    parameter int unsigned NLINES = 32,
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned HALF   = 50000
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic [NLINES-1:0] pad_in,
    input logic [NLINES-1:0] pad_oe,
    input logic [NLINES-1:0] irq_level,
    input logic [NLINES-1:0] pol_q,
    input logic              blink_hold
);
    localparam logic [31:0] LMASK = 32'((64'd1 << NLINES) - 64'd1);

    logic [1:0]  settle_q;
    logic        prev_hold_q;
    logic        seen_q;
    logic [31:0] run_q;
    logic        mapped;

    assign mapped = (bus_addr == ADDR_W'(OFS_OUT))   || (bus_addr == ADDR_W'(OFS_DIR)) ||
                    (bus_addr == ADDR_W'(OFS_BLINK)) || (bus_addr == ADDR_W'(OFS_POL)) ||
                    (bus_addr == ADDR_W'(OFS_DIN));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            settle_q    <= 2'd0;
            prev_hold_q <= 1'b1;
            seen_q      <= 1'b0;
            run_q       <= 32'd0;
        end else begin
            if (settle_q != 2'd2) settle_q <= settle_q + 2'd1;
            prev_hold_q <= blink_hold;
            if (blink_hold != prev_hold_q) begin
                run_q  <= 32'd0;
                seen_q <= 1'b1;
            end else begin
                run_q <= run_q + 32'd1;
            end
        end
    end

    a_r1_inputs_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pad_oe == '0));

    a_r3_dir_write_drives_oe: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADDR_W'(OFS_DIR)) |=> (pad_oe == ~$past(bus_wdata[NLINES-1:0])));

    a_r4_sync_then_polarity: assert property (@(posedge clk) disable iff (!rst_n)
        (settle_q == 2'd2) |-> (irq_level == ($past(pad_in, 2) ^ pol_q)));

    a_r5_blink_half_period: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && blink_hold != prev_hold_q) |-> (run_q == 32'(HALF - 1)));

    a_r6_upper_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_rdata & ~LMASK) == 32'd0));

    a_r8_unmapped_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !mapped |-> (bus_rdata == 32'd0));
endmodule

bind gpio_pol_port gpio_pol_port_chk #(
    .NLINES (NLINES),
    .ADDR_W (ADDR_W),
    .HALF   (BLINK_HALF)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_we     (bus_we),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .pad_in     (pad_in),
    .pad_oe     (pad_oe),
    .irq_level  (irq_level),
    .pol_q      (pol_q),
    .blink_hold (blink_hold)
);

// File: tb/gpio_pol_port_bench.sv
`timescale 1ns/1ps
module gpio_pol_port_bench;
    localparam int N    = 12;
    localparam int AW   = 8;
    localparam int HALF = 3;
    localparam logic [31:0] MASK = 32'h0000_0FFF;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic          bus_we = 1'b0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [N-1:0]  pad_in = '0;
    logic [N-1:0]  pad_oe;
    logic [N-1:0]  pad_out;
    logic [N-1:0]  irq_level;

    int vectors = 0;
    int fails   = 0;
    logic [31:0] m_out, m_dir, m_blink, m_pol;

    always #5 clk = ~clk;

    gpio_pol_port #(.NLINES(N), .ADDR_W(AW), .BLINK_HALF(HALF)) u_gpio_pol_port (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_oe(pad_oe), .pad_out(pad_out), .irq_level(irq_level)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [AW-1:0] a, input logic [31:0] exp);
        @(negedge clk);
        bus_addr = a;
        #1;
        chk(req, bus_rdata, exp);
    endtask

    task automatic regs_chk(input string req);
        rd_chk(req, 8'h00, m_out);
        rd_chk(req, 8'h04, m_dir);
        rd_chk(req, 8'h08, m_blink);
        rd_chk(req, 8'h0C, m_pol);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: reset state
        m_out = 0; m_dir = MASK; m_blink = 0; m_pol = 0;
        #1 chk("R1 pad_oe", 32'(pad_oe), 32'd0);
        regs_chk("R1");

        // R2 R6: walking-bit sweep over every writable register
        for (int r = 0; r < 4; r++) begin
            for (int i = 0; i < 32; i++) begin
                logic [AW-1:0] a;
                a = AW'(r * 4);
                wr(a, 32'd1 << i);
                rd_chk("R2 R6 readback", a, (32'd1 << i) & MASK);
            end
            wr(AW'(r * 4), 32'hFFFF_FFFF);
            rd_chk("R6 all ones", AW'(r * 4), MASK);
        end
        m_out = MASK; m_dir = MASK; m_blink = MASK; m_pol = MASK;

        // R3: direction sweep drives pad_oe one edge after the write
        wr(8'h08, 32'd0); m_blink = 0;
        for (int i = 0; i < 64; i++) begin
            logic [31:0] d;
            d = 32'(i * 32'h0000_0A5B) & MASK;
            wr(8'h04, d);
            chk("R3 pad_oe", 32'(pad_oe), ~d & MASK);
        end
        wr(8'h04, 32'd0); m_dir = 0;
        for (int i = 0; i < 64; i++) begin
            logic [31:0] d;
            d = 32'(i * 32'h0000_0C37 + 5) & MASK;
            wr(8'h00, d);
            chk("R3 pad_out", 32'(pad_out), d);
            m_out = d;
        end

        // R4: two-flop latency
        wr(8'h0C, 32'd0); m_pol = 0;
        @(negedge clk) pad_in = '0;
        repeat (3) @(negedge clk);
        pad_in = 12'h5A3;
        @(negedge clk);
        chk("R4 after one edge", 32'(irq_level), 32'd0);
        @(negedge clk);
        chk("R4 after two edges", 32'(irq_level), 32'h5A3);

        // R4: polarity sweep over pad patterns
        for (int p = 0; p < 4; p++) begin
            logic [31:0] pol;
            pol = (p == 0) ? 32'h000 : (p == 1) ? 32'hFFF : (p == 2) ? 32'hA5A : 32'h0F0;
            wr(8'h0C, pol); m_pol = pol;
            for (int i = 0; i < 256; i++) begin
                logic [N-1:0] pv;
                pv = N'(i * 12'h0A7);
                @(negedge clk) pad_in = pv;
                @(negedge clk);
                @(negedge clk);
                bus_addr = 8'h10;
                #1;
                chk("R4 data-in", bus_rdata, (32'(pv) ^ pol) & MASK);
                chk("R4 irq_level", 32'(irq_level), (32'(pv) ^ pol) & MASK);
            end
        end

        // R7: data-in offset is read-only
        @(negedge clk) pad_in = 12'h3C5;
        wr(8'h10, 32'hFFFF_FFFF);
        wr(8'h10, 32'h0000_0000);
        regs_chk("R7 regs kept");
        rd_chk("R7 data-in kept", 8'h10, (32'h3C5 ^ m_pol) & MASK);
        chk("R7 pad_out kept", 32'(pad_out), m_out);

        // R8: unmapped offsets
        wr(8'h14, 32'hFFFF_FFFF);
        wr(8'h01, 32'h0000_0000);
        wr(8'h80, 32'h0000_0000);
        regs_chk("R8 regs kept");
        rd_chk("R8 unmapped 0x14", 8'h14, 32'd0);
        rd_chk("R8 unmapped 0x01", 8'h01, 32'd0);
        rd_chk("R8 unmapped 0x80", 8'h80, 32'd0);
        rd_chk("R8 unmapped 0xFC", 8'hFC, 32'd0);

        // R5: blink on line 0, line 1 steady, line 2 input with blink
        wr(8'h04, 32'hFFC); m_dir = 32'hFFC;
        wr(8'h00, 32'h003); m_out = 32'h003;
        wr(8'h08, 32'h005); m_blink = 32'h005;
        begin
            logic prev;
            int   guard;
            @(negedge clk);
            prev = pad_out[0];
            guard = 0;
            while (pad_out[0] == prev && guard < 20) begin
                @(negedge clk);
                guard++;
            end
            chk("R5 toggles", 32'(guard < 20), 32'd1);
            for (int k = 0; k < 4; k++) begin
                int run;
                prev = pad_out[0];
                run = 0;
                while (pad_out[0] == prev && run < 20) begin
                    chk("R5 steady line", 32'(pad_out[1]), 32'd1);
                    chk("R5 oe", 32'(pad_oe), 32'h003);
                    @(negedge clk);
                    run++;
                end
                chk("R5 half period", 32'(run), 32'(HALF));
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule